// File: doc/BRIEF.md
# Oscillator Stabilization Wait Gate

This block sits between four free-running oscillator clocks and the rest of the chip. A freshly started oscillator runs unevenly for a while, so each channel keeps its clock output held low until a chosen number of that oscillator's own cycles have gone by since its enable was raised. After that the clock is passed through as whole pulses, and a per-channel ready flag, brought into the bus clock domain, tells software that the clock is usable.

Software picks each channel's wait with a 2-bit code in one 8-bit configuration register. A larger code gives a shorter wait, and reset selects the longest wait on every channel. The channels cover different ranges: two short channels (8 to 64 cycles), a medium channel (128 to 1024) and a long channel (2048 to 16384). The code is taken when a wait begins. Dropping an enable stops that clock at once and clears its ready flag. Each new enable starts a full wait again.

Top module: `osc_wait_gate`

## Requirements
- R1: Bus address 0 is the 8-bit configuration register. A write with `bus_wr` high stores `bus_wdata` at the next `bclk` rising edge, and reading address 0 returns the stored value. Address 1 returns the four synchronized ready flags in bits [3:0] and zeros in bits [7:4]. A write to address 1 changes nothing.
- R2: While `rst_n` is low, the configuration register reads 0x00, every `ready` bit is 0 and every `gclk_out` bit is 0.
- R3: Channel i (0..3) takes its code from configuration bits [2i+1:2i]. Its wait N is MIN_i shifted left by (3 − code), where MIN = 2048, 8, 128 and 8 for channels 0, 1, 2 and 3. Code 3 therefore gives MIN_i, and code 0 gives 8·MIN_i.
- R4: If `osc_en[i]` rises while `osc_clk[i]` is low, `gclk_out[i]` stays low up to and including oscillator rising edge N+2 after the enable. Its first rising edge falls on oscillator rising edge N+3. This count includes two edges for reset synchronization.
- R5: Once a channel's gate has opened, `gclk_out[i]` is high exactly while `osc_clk[i]` is high. Every pulse is full width, and the gate only changes while the oscillator clock is low.
- R6: The code is taken on the first counting edge of a wait. Writing a new code while that wait is in progress does not change its length.
- R7: `ready[i]` rises within four `bclk` edges after the wait ends. It reads 0 during the wait and stays 1 while the enable remains high.
- R8: When `osc_en[i]` drops, `gclk_out[i]` goes low at once, even in the middle of a high phase, and `ready[i]` is 0 within three `bclk` edges. The next enable runs a complete new wait using the code in force at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0: configuration, 1: ready status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| osc_clk | input | 4 | Raw oscillator clocks, one per channel |
| osc_en | input | 4 | Oscillator enables, one per channel |
| gclk_out | output | 4 | Gated oscillator clocks |
| ready | output | 4 | Wait-finished flags in the `bclk` domain |

## Verification
A wrong limit, a misdecoded field or a counter that fails to clear on disable moves the first gated edge of that channel. The edge-index comparison shows this at the very first pulse, N+3 oscillator edges after the enable. A gate register that updated on the rising edge would show up in the full-pulse probe within one oscillator period of opening. A ready synchronizer stuck high, or one not reset by the disable path, shows at the status read a few bus cycles after the enable drops. A code that tracked the register live would shorten the wait under the mid-wait write by more than 50 edges.

// File: rtl/owg_pkg.sv
`timescale 1ns/1ps
package owg_pkg;
  localparam int NUM_CH = 4;
  localparam int CODE_W = 2;
  localparam int REG_W  = NUM_CH * CODE_W;
  localparam int CNT_W  = 16;
  localparam int MAX_CODE = (1 << CODE_W) - 1;

  typedef enum logic {
    ADDR_CFG    = 1'b0,
    ADDR_STATUS = 1'b1
  } owg_addr_e;

  // Larger code -> shorter wait: MIN << (MAX_CODE - code)
  function automatic logic [CNT_W-1:0] wait_len(input int unsigned min_log2,
                                                input logic [CODE_W-1:0] code);
    int unsigned sh;
    logic [CNT_W-1:0] one;
    one = {{(CNT_W-1){1'b0}}, 1'b1};
    sh  = min_log2 + 32'(MAX_CODE) - 32'(code);
    return one << sh;
  endfunction
endpackage

// File: rtl/owg_sync2.sv
`timescale 1ns/1ps
module owg_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/owg_cfg_reg.sv
`timescale 1ns/1ps
module owg_cfg_reg
  import owg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [NUM_CH-1:0] ready_in,
  output logic [REG_W-1:0]  cfg_q,
  output logic [REG_W-1:0]  rdata
);
  logic [REG_W-1:0] cfg_d;
  logic             cfg_en;

  always_comb begin
    cfg_en = wr && (addr == ADDR_CFG);
    cfg_d  = cfg_q;
    if (cfg_en) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    if (addr == ADDR_CFG) rdata = cfg_q;
    else                  rdata = {{(REG_W-NUM_CH){1'b0}}, ready_in};
  end
endmodule

// File: rtl/owg_chan.sv
`timescale 1ns/1ps
module owg_chan
  import owg_pkg::*;
#(
  parameter int unsigned MIN_LOG2 = 3,
  parameter int          CW       = CNT_W
) (
  input  logic              osc_clk,
  input  logic              arst_n,
  input  logic [CODE_W-1:0] code,
  output logic              gclk,
  output logic              done
);
  logic          ch_rst_n;
  logic          loaded_q, loaded_d;
  logic [CW-1:0] limit_q, limit_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;
  logic          gate_q;

  // Reset enters asynchronously, leaves on the oscillator clock
  owg_sync2 #(.W(1)) u_rst_sync (
    .clk    (osc_clk),
    .arst_n (arst_n),
    .d      (1'b1),
    .q      (ch_rst_n)
  );

  always_comb begin
    loaded_d = loaded_q;
    limit_d  = limit_q;
    cnt_d    = cnt_q;
    cnt_en   = loaded_q && !done_q;
    if (!loaded_q) begin
      loaded_d = 1'b1;
      limit_d  = CW'(wait_len(MIN_LOG2, code));
      cnt_d    = {{(CW-1){1'b0}}, 1'b1};
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
    done_d = done_q | (loaded_d && (cnt_d == limit_d));
  end

  always_ff @(posedge osc_clk or negedge ch_rst_n) begin
    if (!ch_rst_n) begin
      loaded_q <= 1'b0;
      limit_q  <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      loaded_q <= loaded_d;
      limit_q  <= limit_d;
      cnt_q    <= cnt_d;
      done_q   <= done_d;
    end
  end

  // Gate updates on the falling edge only, so pulses are never cut
  always_ff @(negedge osc_clk or negedge ch_rst_n) begin
    if (!ch_rst_n) gate_q <= 1'b0;
    else           gate_q <= done_q;
  end

  assign gclk = osc_clk & gate_q;
  assign done = done_q;
endmodule

// File: rtl/osc_wait_gate.sv
`timescale 1ns/1ps
module osc_wait_gate
  import owg_pkg::*;
#(
  parameter int unsigned MIN_LOG2 [NUM_CH] = '{11, 3, 7, 3}
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NUM_CH-1:0] osc_clk,
  input  logic [NUM_CH-1:0] osc_en,
  output logic [NUM_CH-1:0] gclk_out,
  output logic [NUM_CH-1:0] ready
);
  logic [REG_W-1:0]  cfg_q;
  logic [NUM_CH-1:0] chan_done;
  logic [NUM_CH-1:0] chan_arst_n;

  owg_cfg_reg u_cfg (
    .clk      (bclk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .ready_in (ready),
    .cfg_q    (cfg_q),
    .rdata    (bus_rdata)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign chan_arst_n[g] = rst_n & osc_en[g];

    owg_chan #(
      .MIN_LOG2 (MIN_LOG2[g]),
      .CW       (CNT_W)
    ) u_chan (
      .osc_clk (osc_clk[g]),
      .arst_n  (chan_arst_n[g]),
      .code    (cfg_q[g*CODE_W +: CODE_W]),
      .gclk    (gclk_out[g]),
      .done    (chan_done[g])
    );
  end

  owg_sync2 #(.W(NUM_CH)) u_ready_sync (
    .clk    (bclk),
    .arst_n (rst_n),
    .d      (chan_done),
    .q      (ready)
  );
endmodule

// File: rtl/owg_checker.sv
`timescale 1ns/1ps
module owg_checker
  import owg_pkg::*;
(
  input logic              bclk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [NUM_CH-1:0] osc_clk,
  input logic [NUM_CH-1:0] osc_en,
  input logic [NUM_CH-1:0] gclk_out,
  input logic [NUM_CH-1:0] ready,
  input logic [NUM_CH-1:0] chan_done
);
  assert_cfg_write_R1: assert property (@(posedge bclk) disable iff (!rst_n)
    ($past(bus_wr && bus_addr == 1'b0) && bus_addr == 1'b0) |-> bus_rdata == $past(bus_wdata));

  assert_status_upper_zero_R1: assert property (@(posedge bclk) disable iff (!rst_n)
    (bus_addr == 1'b1) |-> bus_rdata[REG_W-1:NUM_CH] == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_gate_after_wait_R4: assert property (@(negedge osc_clk[i]) disable iff (!rst_n)
      gclk_out[i] |-> chan_done[i]);

    assert_done_holds_R7: assert property (@(posedge osc_clk[i]) disable iff (!rst_n || !osc_en[i])
      $past(chan_done[i]) |-> chan_done[i]);

    assert_ready_clears_R8: assert property (@(posedge bclk) disable iff (!rst_n)
      (!osc_en[i] && $past(!osc_en[i]) && $past(!osc_en[i], 2)) |-> !ready[i]);
  end
endmodule

bind osc_wait_gate owg_checker u_owg_checker (
  .bclk      (bclk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .osc_clk   (osc_clk),
  .osc_en    (osc_en),
  .gclk_out  (gclk_out),
  .ready     (ready),
  .chan_done (chan_done)
);

// File: tb/osc_wait_gate_bench.sv
`timescale 1ns/1ps
module osc_wait_gate_bench;
  localparam int NCH = 4;
  localparam int HALF0 = 7;
  localparam int HALF1 = 9;
  localparam int HALF2 = 11;
  localparam int HALF3 = 13;
  localparam int MINS [NCH] = '{2048, 8, 128, 8};

  typedef struct {
    int ch;
    int idx;
  } exp_t;

  logic       bclk;
  logic       rst_n;
  logic       bus_wr;
  logic       bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       oc0, oc1, oc2, oc3;
  logic [3:0] osc_clk;
  logic [3:0] osc_en;
  logic [3:0] gclk_out;
  logic [3:0] ready;

  int   errors;
  int   checks;
  bit   finished;
  logic [7:0] cfg_m;
  exp_t exp_q[$];

  assign osc_clk = {oc3, oc2, oc1, oc0};

  osc_wait_gate u_osc_wait_gate (
    .bclk      (bclk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .osc_clk   (osc_clk),
    .osc_en    (osc_en),
    .gclk_out  (gclk_out),
    .ready     (ready)
  );

  initial begin bclk = 1'b0; forever #5 bclk = ~bclk; end
  initial begin oc0 = 1'b0; forever #(HALF0) oc0 = ~oc0; end
  initial begin oc1 = 1'b0; forever #(HALF1) oc1 = ~oc1; end
  initial begin oc2 = 1'b0; forever #(HALF2) oc2 = ~oc2; end
  initial begin oc3 = 1'b0; forever #(HALF3) oc3 = ~oc3; end

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // Monitor: first gated rising edge per enable, compared to scoreboard
  for (genvar g = 0; g < NCH; g++) begin : g_mon
    initial begin
      int ecnt;
      exp_t e;
      forever begin
        @(posedge osc_en[g]);
        ecnt = 0;
        do begin
          @(posedge osc_clk[g]);
          ecnt++;
          #1;
        end while (!gclk_out[g] && osc_en[g]);
        if (osc_en[g]) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected gated edge", ecnt, 0);
          end else begin
            e = exp_q.pop_front();
            check(e.ch == g, "R3 channel of first gated edge", g, e.ch);
            check(ecnt == e.idx, "R3/R4 first gated edge index", ecnt, e.idx);
          end
        end
      end
    end
  end

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge bclk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bclk);
    bus_wr = 1'b0;
    if (a == 1'b0) cfg_m = d;
  endtask

  task automatic bus_read_chk(input logic a, input logic [7:0] exp_v, input string req);
    @(negedge bclk);
    bus_addr = a;
    #1;
    check(bus_rdata == exp_v, req, int'(bus_rdata), int'(exp_v));
  endtask

  task automatic osc_wait_edges(input int ch, input int n);
    for (int k = 0; k < n; k++) @(posedge osc_clk[ch]);
  endtask

  task automatic set_en(input int ch, input logic v);
    @(negedge osc_clk[ch]);
    #1;
    osc_en[ch] = v;
  endtask

  // Driver: one complete wait on one channel
  task automatic run_wait(input int ch, input int code, input bit mid_write, input int mid_code);
    logic [7:0] c;
    exp_t e;
    int n;
    c = cfg_m;
    c[ch*2 +: 2] = 2'(code);
    bus_write(1'b0, c);
    n = MINS[ch] << (3 - code);
    e.ch = ch; e.idx = n + 3;
    exp_q.push_back(e);
    set_en(ch, 1'b1);
    if (mid_write) begin
      osc_wait_edges(ch, 10);
      c = cfg_m;
      c[ch*2 +: 2] = 2'(mid_code);
      bus_write(1'b0, c);
    end
    if (n >= 40) begin
      osc_wait_edges(ch, 30);
      #2;
      check(ready[ch] == 1'b0, "R7 ready low during wait", int'(ready[ch]), 0);
      check(gclk_out[ch] == 1'b0, "R4 no gated clock during wait", int'(gclk_out[ch]), 0);
    end
    wait (exp_q.size() == 0);
    repeat (4) @(posedge bclk);
    #2;
    check(ready[ch] == 1'b1, "R7 ready after wait", int'(ready[ch]), 1);
    bus_read_chk(1'b1, {4'b0, ready}, "R1 status read");
    for (int k = 0; k < 3; k++) begin
      @(posedge osc_clk[ch]); #2;
      check(gclk_out[ch] == 1'b1, "R5 gated high with osc", int'(gclk_out[ch]), 1);
      @(negedge osc_clk[ch]); #2;
      check(gclk_out[ch] == 1'b0, "R5 gated low with osc", int'(gclk_out[ch]), 0);
    end
    check(ready[ch] == 1'b1, "R7 ready held", int'(ready[ch]), 1);
    // R8: drop enable in the middle of a high phase
    @(posedge osc_clk[ch]); #2;
    osc_en[ch] = 1'b0;
    #1;
    check(gclk_out[ch] == 1'b0, "R8 gated clock stops at once", int'(gclk_out[ch]), 0);
    repeat (4) @(posedge bclk);
    #2;
    check(ready[ch] == 1'b0, "R8 ready cleared", int'(ready[ch]), 0);
    osc_wait_edges(ch, 2);
  endtask

  initial begin
    errors = 0; checks = 0; finished = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = 8'h00;
    osc_en = 4'b0; cfg_m = 8'h00;
    repeat (3) @(posedge bclk);
    #2;
    // R2 reset state
    check(bus_rdata == 8'h00, "R2 config reset", int'(bus_rdata), 0);
    check(ready == 4'b0, "R2 ready reset", int'(ready), 0);
    check(gclk_out == 4'b0, "R2 gated clocks reset", int'(gclk_out), 0);
    @(negedge bclk);
    rst_n = 1'b1;
    bus_read_chk(1'b0, 8'h00, "R2 config default after reset");
    // R1 register access
    bus_write(1'b0, 8'hE4);
    bus_read_chk(1'b0, 8'hE4, "R1 config readback");
    bus_write(1'b1, 8'hFF);
    bus_read_chk(1'b0, 8'hE4, "R1 status write ignored");
    bus_read_chk(1'b1, 8'h00, "R1 status read idle");
    bus_write(1'b0, 8'h00);
    // R3/R4 per-channel decoding
    run_wait(3, 3, 1'b0, 0);
    run_wait(3, 2, 1'b0, 0);
    run_wait(3, 1, 1'b0, 0);
    run_wait(3, 0, 1'b0, 0);
    run_wait(1, 3, 1'b0, 0);
    run_wait(1, 0, 1'b0, 0);
    run_wait(2, 3, 1'b0, 0);
    run_wait(2, 0, 1'b0, 0);
    run_wait(0, 3, 1'b0, 0);
    run_wait(0, 0, 1'b0, 0);
    // R6: mid-wait write keeps the sampled length (64 -> expect 67)
    run_wait(1, 0, 1'b1, 3);
    // R8 restart: fresh wait with the code now in force
    check(cfg_m[3:2] == 2'd3, "R6 model code", int'(cfg_m[3:2]), 3);
    run_wait(1, 3, 1'b0, 0);
    bus_read_chk(1'b0, cfg_m, "R1 config after runs");
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule